// File: doc/BRIEF.md
# Direct-Mapped Cache with Selectable Write Policy

This block is a direct-mapped cache between a processor load/store port and a one-word-wide memory bus. Each line holds a valid bit, a tag and a block of words. In write-back builds each line also holds a dirty bit. An access is split into a byte offset (low bits), a line index (the bits just above the offset) and a tag (all remaining high bits). Only the tag is stored. A hit needs the line to be valid and its stored tag to equal the address tag. On a miss the processor is stalled while the sequencer fetches the whole line over the bus.

The parameter `WRITE_BACK` selects the write policy.

- **Write-through (0):** every store goes into a small address/data FIFO, and the FIFO drains to memory in the background. The parameter `WRITE_ALLOC` then decides what a store miss does. With allocate, the line is fetched first and the store then hits. With write-around, the store goes to the FIFO only and the line is left untouched.
- **Write-back (1):** a store updates only the line and marks it dirty. A dirty line that is displaced is written out as a whole burst before the refill read starts.

Every bus burst has the same timing. One cycle carries the address (`mem_cmd`). Each word then takes `ACCESS_CYC` wait cycles followed by one transfer cycle (`mem_xfer`). At the data-in edge of a read transfer the memory presents the addressed word on `mem_rdata`. At a write transfer the cache drives `mem_wdata`. Word k of a burst belongs to the address sent in the address cycle plus k words.

The controller FSM has five states:

| State | Meaning | Exit |
|-------|---------|------|
| `C_RUN` | Serves hits. | On a miss that needs the line: to `C_EVICT` if the victim is dirty, to `C_FILL` if the bus and FIFO are idle, otherwise to `C_DRAIN`. |
| `C_DRAIN` | Waits until the store FIFO is empty and the bus is free. | Starts the refill, then goes to `C_FILL`. |
| `C_EVICT` | Writes the dirty victim line out. | To `C_FILLGO` when the victim burst ends. |
| `C_FILLGO` | Launches the refill. | To `C_FILL`. |
| `C_FILL` | Stores each arriving word into the line. | Marks the line valid and clean, then back to `C_RUN` on the last word. |

The bus sequencer moves `B_IDLE` → `B_ADDR` → `B_WAIT` → `B_XFER`. After `B_XFER` it returns to `B_WAIT` for the next word, or to `B_IDLE` after the last word.

Top module: `dmc_cache`

## Requirements
- R1: The line is chosen by address bits [OFF_W+IDX_W-1:OFF_W] (bits [6:4] with 8 lines of 16 bytes). Two addresses with the same index and different tags evict each other. Lines at other indices are unaffected.
- R2: After reset `cpu_stall` and `mem_cmd` are low, and every line is invalid, so the first read of any line misses.
- R3: A read hit returns the stored word on `cpu_rdata` in the same cycle with `cpu_stall` low.
- R4: A read miss with an idle bus and an empty FIFO keeps `cpu_stall` high for exactly 66 cycles. The refill burst spans 65 bus cycles (1 address cycle plus 4×(15+1)) and carries 4 transfers.
- R5: A write-through store hit updates the line without stalling. Memory receives the word through a single-word burst lasting 17 cycles.
- R6: The write-through FIFO holds 4 entries. A store that finds it full stalls until the oldest entry completes its bus write (15 stall cycles for the 5th of five back-to-back stores to an idle bus).
- R7: A read miss with pending buffered stores first drains the FIFO and then refills, so the refilled line shows the newest stored data.
- R8: With write-around, a store miss does not stall when the FIFO has room and does not replace the resident line.
- R9: With write-allocate, a store miss fetches the line (66 stall cycles) before the store completes. The store then reaches both the line and memory.
- R10: With write-back, a store hit updates only the line. Memory keeps its old value.
- R11: With write-back, a miss on a dirty line writes all 4 victim words to memory before refilling, for 132 stall cycles.
- R12: With write-back, a store miss always fetches the line and leaves memory untouched.
- R13: With write-back, replacing a clean line issues no write burst, for 66 stall cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, held until `cpu_stall` is low |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address (word aligned) |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid when a load is not stalled |
| cpu_stall | output | 1 | Access not yet complete |
| mem_cmd | output | 1 | Address cycle of a bus burst |
| mem_we | output | 1 | Burst direction, 1 = write |
| mem_addr | output | ADDR_W | Burst start address |
| mem_xfer | output | 1 | Data transfer cycle |
| mem_wdata | output | 32 | Write data on a write transfer |
| mem_rdata | input | 32 | Read data on a read transfer |

## Verification
The assertions rely on two things from the outside. First, the processor keeps `cpu_req`, `cpu_we`, `cpu_addr` and `cpu_wdata` steady while `cpu_stall` is high. Second, the memory answers on exactly the fixed transfer cycles, with no handshake of its own. The bench keeps to both rules. Its access task drives the request once, waits with all fields unchanged until the stall clears, and only then drops the request. Its memory model latches the burst address on `mem_cmd` and serves or stores one word per `mem_xfer`. The stimulus sweeps every line of an 8-line configuration under each of the three policy builds. It then compares loads with a shadow copy, memory contents with expected values and stall lengths with cycle counts worked out from the burst timing.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    typedef enum logic [2:0] {
        C_RUN,
        C_DRAIN,
        C_EVICT,
        C_FILLGO,
        C_FILL
    } ctl_state_t;

    typedef enum logic [1:0] {
        B_IDLE,
        B_ADDR,
        B_WAIT,
        B_XFER
    } bus_state_t;

endpackage

// File: rtl/dmc_bus_seq.sv
module dmc_bus_seq
    import dmc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WORDS      = 4,
    parameter int ACCESS_CYC = 15
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     start_we,
    input  logic                     start_burst,
    input  logic [ADDR_W-1:0]        start_addr,
    output logic                     busy,
    output logic                     done,
    output logic [$clog2(WORDS)-1:0] word_idx,
    output logic                     mem_cmd,
    output logic                     mem_we,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic                     mem_xfer
);
    localparam int WSEL_W = $clog2(WORDS);
    localparam int WAIT_W = $clog2(ACCESS_CYC + 1);

    bus_state_t        st, nxt;
    logic [WAIT_W-1:0] wcnt;
    logic [WSEL_W-1:0] idx_q;
    logic              burst_q, we_q, last;
    logic [ADDR_W-1:0] addr_q;

    assign last = !burst_q || (idx_q == WSEL_W'(WORDS - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= B_IDLE;
            wcnt    <= '0;
            idx_q   <= '0;
            burst_q <= 1'b0;
            we_q    <= 1'b0;
            addr_q  <= '0;
        end else begin
            st <= nxt;
            unique case (st)
                B_IDLE: if (start) begin
                    addr_q  <= start_addr;
                    we_q    <= start_we;
                    burst_q <= start_burst;
                    idx_q   <= '0;
                end
                B_ADDR: wcnt <= '0;
                B_WAIT: wcnt <= wcnt + 1'b1;
                B_XFER: begin
                    idx_q <= idx_q + 1'b1;
                    wcnt  <= '0;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        nxt      = st;
        mem_cmd  = 1'b0;
        mem_xfer = 1'b0;
        done     = 1'b0;
        unique case (st)
            B_IDLE: if (start) nxt = B_ADDR;
            B_ADDR: begin
                mem_cmd = 1'b1;
                nxt     = B_WAIT;
            end
            B_WAIT: if (wcnt == WAIT_W'(ACCESS_CYC - 1)) nxt = B_XFER;
            B_XFER: begin
                mem_xfer = 1'b1;
                done     = last;
                nxt      = last ? B_IDLE : B_WAIT;
            end
            default: nxt = B_IDLE;
        endcase
    end

    assign busy     = (st != B_IDLE);
    assign word_idx = idx_q;
    assign mem_we   = we_q;
    assign mem_addr = addr_q;

    // R4: the address phase lasts exactly one cycle
    p_single_addr_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cmd |=> !mem_cmd);
    // R4: a transfer never directly follows the address cycle
    p_wait_after_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cmd |=> !mem_xfer);
    // R4: a new burst is never accepted while one is running
    p_start_when_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |-> !mem_cmd || !start);
endmodule

// File: rtl/dmc_wbuf.sv
module dmc_wbuf #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [ADDR_W-1:0] head_addr,
    output logic [DATA_W-1:0] head_data,
    output logic              empty,
    output logic              full
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    logic [ADDR_W-1:0] a_q [DEPTH];
    logic [DATA_W-1:0] d_q [DEPTH];
    logic [PTR_W-1:0]  wp, rp;
    logic [CNT_W-1:0]  cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
            cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            a_q[wp] <= push_addr;
            d_q[wp] <= push_data;
        end
    end

    assign head_addr = a_q[rp];
    assign head_data = d_q[rp];
    assign empty     = (cnt == '0);
    assign full      = (cnt == CNT_W'(DEPTH));

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/dmc_line_store.sv
module dmc_line_store #(
    parameter int LINES  = 64,
    parameter int WORDS  = 4,
    parameter int TAG_W  = 22,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(LINES)-1:0] idx,
    input  logic [$clog2(WORDS)-1:0] rd_word,
    input  logic [$clog2(WORDS)-1:0] ev_word,
    output logic [DATA_W-1:0]        rd_data,
    output logic [DATA_W-1:0]        ev_data,
    output logic [TAG_W-1:0]         line_tag,
    output logic                     line_valid,
    output logic                     line_dirty,
    input  logic                     wr_en,
    input  logic [$clog2(WORDS)-1:0] wr_word,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     set_line,
    input  logic [TAG_W-1:0]         set_tag,
    input  logic                     set_dirty
);
    localparam int IDX_W  = $clog2(LINES);
    localparam int WSEL_W = $clog2(WORDS);

    logic [DATA_W-1:0] data_q [LINES*WORDS];
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [LINES-1:0]  valid_q, dirty_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            if (set_line) begin
                valid_q[idx] <= 1'b1;
                dirty_q[idx] <= 1'b0;
            end else if (set_dirty) begin
                dirty_q[idx] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (set_line) tag_q[idx] <= set_tag;
        if (wr_en)    data_q[{idx, wr_word}] <= wr_data;
    end

    assign rd_data    = data_q[{idx, rd_word}];
    assign ev_data    = data_q[{idx, ev_word}];
    assign line_tag   = tag_q[idx];
    assign line_valid = valid_q[idx];
    assign line_dirty = dirty_q[idx];

    // R11: dirty is never set on a line that holds no data
    p_dirty_needs_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        set_dirty |-> (line_valid || set_line));
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache
    import dmc_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int LINES       = 64,
    parameter int LINE_BYTES  = 16,
    parameter bit WRITE_BACK  = 1'b0,
    parameter bit WRITE_ALLOC = 1'b1,
    parameter int ACCESS_CYC  = 15,
    parameter int WBUF_DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [31:0]       cpu_wdata,
    output logic [31:0]       cpu_rdata,
    output logic              cpu_stall,
    output logic              mem_cmd,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_xfer,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata
);
    localparam int WORDS  = LINE_BYTES / 4;
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int WSEL_W = $clog2(WORDS);
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;

    ctl_state_t st, nxt;

    logic [TAG_W-1:0]  a_tag, l_tag;
    logic [IDX_W-1:0]  a_idx;
    logic [WSEL_W-1:0] a_word, seq_word, wr_word;
    logic              l_valid, l_dirty, hit;
    logic [31:0]       rd_data, ev_data, wr_data;
    logic              line_wr, set_line, set_dirty;
    logic              seq_start, seq_we, seq_burst, seq_busy, seq_done;
    logic [ADDR_W-1:0] seq_addr, line_base, victim_base, head_addr;
    logic              push, pop, wb_empty, wb_full, drain_go;
    logic [31:0]       head_data;

    assign a_tag       = cpu_addr[ADDR_W-1 -: TAG_W];
    assign a_idx       = cpu_addr[OFF_W +: IDX_W];
    assign a_word      = cpu_addr[2 +: WSEL_W];
    assign hit         = l_valid && (l_tag == a_tag);
    assign line_base   = {a_tag, a_idx, {OFF_W{1'b0}}};
    assign victim_base = {l_tag, a_idx, {OFF_W{1'b0}}};

    dmc_line_store #(
        .LINES(LINES), .WORDS(WORDS), .TAG_W(TAG_W), .DATA_W(32)
    ) store_i (
        .clk(clk), .rst_n(rst_n), .idx(a_idx),
        .rd_word(a_word), .ev_word(seq_word),
        .rd_data(rd_data), .ev_data(ev_data),
        .line_tag(l_tag), .line_valid(l_valid), .line_dirty(l_dirty),
        .wr_en(line_wr), .wr_word(wr_word), .wr_data(wr_data),
        .set_line(set_line), .set_tag(a_tag), .set_dirty(set_dirty)
    );

    dmc_bus_seq #(
        .ADDR_W(ADDR_W), .WORDS(WORDS), .ACCESS_CYC(ACCESS_CYC)
    ) seq_i (
        .clk(clk), .rst_n(rst_n),
        .start(seq_start), .start_we(seq_we), .start_burst(seq_burst),
        .start_addr(seq_addr), .busy(seq_busy), .done(seq_done),
        .word_idx(seq_word), .mem_cmd(mem_cmd), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_xfer(mem_xfer)
    );

    generate
        if (!WRITE_BACK) begin : g_wbuf
            dmc_wbuf #(
                .DEPTH(WBUF_DEPTH), .ADDR_W(ADDR_W), .DATA_W(32)
            ) wbuf_i (
                .clk(clk), .rst_n(rst_n),
                .push(push), .push_addr(cpu_addr), .push_data(cpu_wdata),
                .pop(pop), .head_addr(head_addr), .head_data(head_data),
                .empty(wb_empty), .full(wb_full)
            );
            assign mem_wdata = head_data;
        end else begin : g_nobuf
            assign head_addr = '0;
            assign head_data = '0;
            assign wb_empty  = 1'b1;
            assign wb_full   = 1'b0;
            assign mem_wdata = ev_data;
        end
    endgenerate

    assign cpu_rdata = rd_data;
    assign drain_go  = !WRITE_BACK && !wb_empty && !seq_busy &&
                       (st == C_RUN || st == C_DRAIN);
    assign pop       = !WRITE_BACK && seq_done && (st != C_FILL);

    always_ff @(posedge clk) begin
        if (!rst_n) st <= C_RUN;
        else        st <= nxt;
    end

    always_comb begin
        nxt       = st;
        cpu_stall = 1'b0;
        seq_start = 1'b0;
        seq_we    = 1'b0;
        seq_burst = 1'b0;
        seq_addr  = line_base;
        push      = 1'b0;
        line_wr   = 1'b0;
        wr_word   = a_word;
        wr_data   = cpu_wdata;
        set_line  = 1'b0;
        set_dirty = 1'b0;

        if (drain_go) begin
            seq_start = 1'b1;
            seq_we    = 1'b1;
            seq_addr  = head_addr;
        end

        unique case (st)
            C_RUN: if (cpu_req) begin
                if (hit) begin
                    if (!cpu_we) begin
                        cpu_stall = 1'b0;
                    end else if (WRITE_BACK) begin
                        line_wr   = 1'b1;
                        set_dirty = 1'b1;
                    end else if (wb_full) begin
                        cpu_stall = 1'b1;
                    end else begin
                        line_wr = 1'b1;
                        push    = 1'b1;
                    end
                end else if (cpu_we && !WRITE_BACK && !WRITE_ALLOC) begin
                    if (wb_full) cpu_stall = 1'b1;
                    else         push      = 1'b1;
                end else begin
                    cpu_stall = 1'b1;
                    if (WRITE_BACK && l_valid && l_dirty) begin
                        seq_start = 1'b1;
                        seq_we    = 1'b1;
                        seq_burst = 1'b1;
                        seq_addr  = victim_base;
                        nxt       = C_EVICT;
                    end else if (wb_empty && !seq_busy) begin
                        seq_start = 1'b1;
                        seq_burst = 1'b1;
                        seq_addr  = line_base;
                        nxt       = C_FILL;
                    end else begin
                        nxt = C_DRAIN;
                    end
                end
            end
            C_DRAIN: begin
                cpu_stall = 1'b1;
                if (wb_empty && !seq_busy) begin
                    seq_start = 1'b1;
                    seq_burst = 1'b1;
                    seq_addr  = line_base;
                    nxt       = C_FILL;
                end
            end
            C_EVICT: begin
                cpu_stall = 1'b1;
                if (seq_done) nxt = C_FILLGO;
            end
            C_FILLGO: begin
                cpu_stall = 1'b1;
                seq_start = 1'b1;
                seq_burst = 1'b1;
                seq_addr  = line_base;
                nxt       = C_FILL;
            end
            C_FILL: begin
                cpu_stall = 1'b1;
                if (mem_xfer) begin
                    line_wr = 1'b1;
                    wr_word = seq_word;
                    wr_data = mem_rdata;
                end
                if (seq_done) begin
                    set_line = 1'b1;
                    nxt      = C_RUN;
                end
            end
            default: nxt = C_RUN;
        endcase
    end

    // R7: a refill read is only issued once no buffered store is pending
    p_fill_after_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cmd && !mem_we) |-> wb_empty);
    // R10: in write-back builds memory is only written by victim bursts
    p_wb_writes_only_evict_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (WRITE_BACK && mem_cmd && mem_we) |-> (st == C_EVICT));
    // R4: a held request completes in the cycle after the last refill word
    p_hit_after_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == C_FILL && seq_done && cpu_req) |=> !cpu_stall);
    // R11: the refill read follows the victim burst directly
    p_evict_then_fill_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == C_EVICT && seq_done) |=> (st == C_FILLGO));
endmodule

// File: tb/dmc_cache_tb.sv
module dmc_env #(
    parameter bit WB = 1'b0,
    parameter bit WA = 1'b1
) (
    input  logic clk,
    output int   n_chk,
    output int   n_fail,
    output logic fin
);
    localparam int AW = 32;

    logic        rst_n, req, wen, stall, mcmd, mwe, mxfer;
    logic [31:0] addr, wdat, rdata, maddr, mwdata, mrdata;
    logic [31:0] mem  [1024];
    logic [31:0] refm [1024];
    logic [9:0]  base, k;
    logic        wel;
    int          cur_cyc, cur_len, last_cyc, last_len;
    string       nm;

    dmc_cache #(
        .ADDR_W(AW), .LINES(8), .LINE_BYTES(16), .WRITE_BACK(WB),
        .WRITE_ALLOC(WA), .ACCESS_CYC(15), .WBUF_DEPTH(4)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_req(req), .cpu_we(wen),
        .cpu_addr(addr), .cpu_wdata(wdat), .cpu_rdata(rdata),
        .cpu_stall(stall), .mem_cmd(mcmd), .mem_we(mwe), .mem_addr(maddr),
        .mem_xfer(mxfer), .mem_wdata(mwdata), .mem_rdata(mrdata)
    );

    function automatic logic [31:0] init_val(input int i);
        return 32'h5A000000 ^ (i * 32'h00010203);
    endfunction

    function automatic logic [31:0] mk(input int tag, input int idx, input int w);
        return 32'((tag << 7) | (idx << 4) | (w << 2));
    endfunction

    assign mrdata = mem[base + k];

    always @(posedge clk) begin
        if (mcmd) begin
            base    <= maddr[11:2];
            k       <= '0;
            wel     <= mwe;
            cur_cyc <= 1;
            cur_len <= 0;
        end else begin
            cur_cyc <= cur_cyc + 1;
        end
        if (mxfer) begin
            if (wel) mem[base + k] <= mwdata;
            k        <= k + 1'b1;
            cur_len  <= cur_len + 1;
            last_len <= cur_len + 1;
            last_cyc <= cur_cyc + 1;
        end
    end

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", nm, rq, act, exp);
        end
    endtask

    task automatic acc(input bit we, input logic [31:0] a, input logic [31:0] d,
                       output logic [31:0] rd, output int st);
        st = 0;
        @(negedge clk);
        req = 1'b1; wen = we; addr = a; wdat = d;
        #1;
        while (stall) begin
            st++;
            @(negedge clk);
            #1;
        end
        rd = rdata;
        @(posedge clk);
        #1;
        req = 1'b0; wen = 1'b0;
        if (we) refm[a[11:2]] = d;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] rd;
        int          st;
        nm = WB ? "wb" : (WA ? "wt_alloc" : "wt_around");
        n_chk = 0; n_fail = 0; fin = 1'b0;
        cur_cyc = 0; cur_len = 0; last_cyc = 0; last_len = 0;
        base = '0; k = '0; wel = 1'b0;
        for (int i = 0; i < 1024; i++) begin
            mem[i]  = init_val(i);
            refm[i] = init_val(i);
        end
        rst_n = 1'b0; req = 1'b0; wen = 1'b0; addr = '0; wdat = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R2 stall low in reset", {31'b0, stall}, 32'd0);
        chk("R2 no bus cycle in reset", {31'b0, mcmd}, 32'd0);
        rst_n = 1'b1;

        // R1 R2 R3 R4: cold sweep over every line
        for (int i = 0; i < 8; i++) begin
            acc(1'b0, mk(1, i, 0), 32'h0, rd, st);
            chk("R2 R4 cold miss stall", st, 66);
            chk("R4 refill data", rd, refm[mk(1, i, 0) >> 2]);
            if (i == 0) begin
                chk("R4 refill transfers", last_len, 4);
                chk("R4 refill bus cycles", last_cyc, 65);
            end
            for (int w = 1; w < 4; w++) begin
                acc(1'b0, mk(1, i, w), 32'h0, rd, st);
                chk("R3 read hit stall", st, 0);
                chk("R3 read hit data", rd, refm[mk(1, i, w) >> 2]);
            end
        end

        // R1: conflict at one index, others untouched
        acc(1'b0, mk(2, 3, 1), 32'h0, rd, st);
        chk("R1 conflict miss", st, 66);
        chk("R1 conflict data", rd, refm[mk(2, 3, 1) >> 2]);
        acc(1'b0, mk(1, 3, 1), 32'h0, rd, st);
        chk("R1 displaced line misses", st, 66);
        acc(1'b0, mk(1, 4, 2), 32'h0, rd, st);
        chk("R1 other index still hits", st, 0);

        // write hit
        acc(1'b1, mk(1, 5, 0), 32'hD00DF00D, rd, st);
        chk(WB ? "R10 write hit stall" : "R5 write hit stall", st, 0);
        acc(1'b0, mk(1, 5, 0), 32'h0, rd, st);
        chk("R3 read after write", rd, 32'hD00DF00D);
        idle(40);
        if (!WB) begin
            chk("R5 memory updated", mem[mk(1, 5, 0) >> 2], 32'hD00DF00D);
            chk("R5 single word burst", last_len, 1);
            chk("R5 store burst cycles", last_cyc, 17);
            acc(1'b0, mk(2, 5, 0), 32'h0, rd, st);
            chk("R4 miss after drain", st, 66);
        end else begin
            chk("R10 memory unchanged", mem[mk(1, 5, 0) >> 2], init_val(mk(1, 5, 0) >> 2));
            acc(1'b0, mk(2, 5, 0), 32'h0, rd, st);
            chk("R11 dirty eviction stall", st, 132);
            chk("R11 data after eviction", rd, refm[mk(2, 5, 0) >> 2]);
            for (int w = 0; w < 4; w++)
                chk("R11 victim word in memory", mem[mk(1, 5, w) >> 2], refm[mk(1, 5, w) >> 2]);
            acc(1'b0, mk(1, 5, 0), 32'h0, rd, st);
            chk("R13 clean eviction stall", st, 66);
            chk("R13 reloaded data", rd, 32'hD00DF00D);
        end

        // write miss on index 6 (holds tag 1)
        acc(1'b1, mk(3, 6, 2), 32'hE1E2E3E4, rd, st);
        if (WB) begin
            chk("R12 write miss fetches", st, 66);
            acc(1'b0, mk(3, 6, 2), 32'h0, rd, st);
            chk("R12 store in line", rd, 32'hE1E2E3E4);
            idle(40);
            chk("R12 memory untouched", mem[mk(3, 6, 2) >> 2], init_val(mk(3, 6, 2) >> 2));
        end else if (WA) begin
            chk("R9 write miss fetches", st, 66);
            acc(1'b0, mk(3, 6, 2), 32'h0, rd, st);
            chk("R9 line holds store", rd, 32'hE1E2E3E4);
            chk("R9 read hit after allocate", st, 0);
            idle(40);
            chk("R9 memory written", mem[mk(3, 6, 2) >> 2], 32'hE1E2E3E4);
        end else begin
            chk("R8 write around no stall", st, 0);
            acc(1'b0, mk(1, 6, 0), 32'h0, rd, st);
            chk("R8 resident line kept", st, 0);
            acc(1'b0, mk(3, 6, 2), 32'h0, rd, st);
            chk("R7 drain before refill", st, 83);
            chk("R7 refill not stale", rd, 32'hE1E2E3E4);
        end

        // R6: buffer fills up
        if (!WB) begin
            idle(40);
            for (int j = 0; j < 5; j++) begin
                int lines_used [5] = '{0, 1, 2, 4, 7};
                acc(1'b1, mk(1, lines_used[j], 3), 32'hB0B00000 + j, rd, st);
                chk("R6 store stall", st, (j == 4) ? 15 : 0);
            end
            idle(120);
            chk("R6 first store landed", mem[mk(1, 0, 3) >> 2], 32'hB0B00000);
            chk("R6 last store landed", mem[mk(1, 7, 3) >> 2], 32'hB0B00004);
        end
        fin = 1'b1;
    end
endmodule

module dmc_cache_tb_top;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    int   c0, f0, c1, f1, c2, f2;
    logic d0, d1, d2;

    dmc_env #(.WB(1'b0), .WA(1'b1)) env_alloc_i (.clk(clk), .n_chk(c0), .n_fail(f0), .fin(d0));
    dmc_env #(.WB(1'b0), .WA(1'b0)) env_around_i (.clk(clk), .n_chk(c1), .n_fail(f1), .fin(d1));
    dmc_env #(.WB(1'b1), .WA(1'b1)) env_wb_i (.clk(clk), .n_chk(c2), .n_fail(f2), .fin(d2));

    initial begin
        int cyc = 0;
        int tot, bad;
        bit timed_out = 1'b0;
        #1;
        while (!(d0 === 1'b1 && d1 === 1'b1 && d2 === 1'b1)) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                timed_out = 1'b1;
                break;
            end
        end
        tot = c0 + c1 + c2;
        bad = f0 + f1 + f2;
        if (timed_out) begin
            tot++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("  %0d/%0d checks passed", tot - bad, tot);
        $finish;
    end
endmodule